// File: doc/BRIEF.md
# Serial Divider Programming Port

This block is the control port of a frequency synthesizer's divider chain. A host drives three lines: serial data, serial clock and latch enable. Each rising edge of the serial clock pushes one data bit into a 19-bit shift register, and the most significant bit is sent first. When latch enable rises, the block copies the assembled word into one of two holding registers. The bit that arrives last, bit 0 of the word, is the routing bit that picks the register. The holding registers drive the downstream counters directly.

One holding register sets up the reference path: a 14-bit reference division ratio and four mode flags. The flags are prescaler modulus select, phase comparator polarity, lock-detect/divided-frequency output select and charge pump current select. The other holding register sets up the main divider: an 11-bit programmable count N and a 7-bit swallow count A. The three serial lines are asynchronous to the block clock. They pass through a two-stage synchronizer, and their edges are detected in the block clock domain.

Top module: `serdiv_prog_port`

## Requirements
- R1: When synchronous reset is asserted, the reference ratio becomes 3, all four reference flags become 0, N becomes 3 and A becomes 0.
- R2: Each rising edge of the serial clock shifts the data line into bit 0 and moves every earlier bit up one place, so data is sent most significant bit first. If more than 19 bits are shifted, only the last 19 bits are kept.
- R3: Latching a word whose bit 0 is 1 loads the reference register from that word. Bits 14:1 hold the ratio (LSB at bit 1), bit 15 selects the prescaler modulus, bit 16 sets comparator polarity, bit 17 selects the lock-detect output and bit 18 selects the charge pump current.
- R4: Latching a word whose bit 0 is 0 loads the main divider register from that word. Bits 7:1 hold A (LSB at bit 1) and bits 18:8 hold N (LSB at bit 8).
- R5: The holding registers change only on a rising edge of latch enable. Shifting while latch enable is low leaves them unchanged. Shifting while latch enable stays high also leaves them unchanged.
- R6: A reference latch leaves N and A unchanged. A main-divider latch leaves the reference ratio and the four flags unchanged.
- R7: A rising edge of latch enable that is seen before clock edge k updates the outputs at clock edge k+2. The outputs keep their old values after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; it oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial clock; a bit is taken on its rising edge |
| ser_le | input | 1 | Latch enable; its rising edge transfers the word |
| ref_ratio | output | 14 | Reference division ratio |
| ref_sw | output | 1 | Prescaler modulus select (0: 32/33, 1: 64/65) |
| ref_fc | output | 1 | Phase comparator polarity |
| ref_lds | output | 1 | Lock-detect / divided-frequency output select |
| ref_cs | output | 1 | Charge pump current select |
| prog_n | output | 11 | Main divider count N |
| prog_a | output | 7 | Swallow count A |

## Verification
The bench shifts more than 19 bits before a latch. A design that counted bits, or kept the first bits sent, would then latch a misaligned word. The bench shifts whole words while latch enable is low, and also while it is held high. A design that latched on the level of latch enable would change its outputs during that shifting. Each latch is followed by a check that the other register did not move, which catches swapped or shared write enables. The bench also checks the output one cycle before and on the cycle of the update. This exposes a missing or extra synchronizer stage. All-ones words at the maximum ratio and counts catch field slices that are shifted by one bit.

// File: rtl/serdiv_pkg.sv
package serdiv_pkg;

    localparam int WORD_W      = 19;
    localparam int RATIO_W     = 14;
    localparam int N_W         = 11;
    localparam int A_W         = 7;
    localparam int SYNC_STAGES = 2;
    localparam int RATIO_MIN   = 3;
    localparam int N_MIN       = 3;

    localparam int RATIO_LSB = 1;
    localparam int SW_POS    = RATIO_LSB + RATIO_W;
    localparam int FC_POS    = SW_POS + 1;
    localparam int LDS_POS   = FC_POS + 1;
    localparam int CS_POS    = LDS_POS + 1;
    localparam int A_LSB     = 1;
    localparam int N_LSB     = A_LSB + A_W;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic               cs;
        logic               lds;
        logic               fc;
        logic               sw;
        logic [RATIO_W-1:0] ratio;
    } ref_cfg_t;

    typedef struct packed {
        logic [N_W-1:0] n;
        logic [A_W-1:0] a;
    } prog_cfg_t;

    localparam ref_cfg_t REF_RST = '{cs: 1'b0, lds: 1'b0, fc: 1'b0, sw: 1'b0,
                                     ratio: RATIO_W'(RATIO_MIN)};
    localparam prog_cfg_t PROG_RST = '{n: N_W'(N_MIN), a: '0};

    function automatic ref_cfg_t word_to_ref(input word_t w);
        ref_cfg_t r;
        r.ratio = w[RATIO_LSB +: RATIO_W];
        r.sw    = w[SW_POS];
        r.fc    = w[FC_POS];
        r.lds   = w[LDS_POS];
        r.cs    = w[CS_POS];
        return r;
    endfunction

    function automatic prog_cfg_t word_to_prog(input word_t w);
        prog_cfg_t p;
        p.a = w[A_LSB +: A_W];
        p.n = w[N_LSB +: N_W];
        return p;
    endfunction

endpackage

// File: rtl/serdiv_sync.sv
module serdiv_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/serdiv_edge.sv
module serdiv_edge #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level;
    end

    assign rise = level & ~prev_q;
endmodule

// File: rtl/serdiv_shreg.sv
module serdiv_shreg
    import serdiv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  shift_en,
    input  logic  bit_in,
    output word_t word
);
    word_t sr_q;

    always_ff @(posedge clk) begin
        if (rst)           sr_q <= '0;
        else if (shift_en) sr_q <= {sr_q[WORD_W-2:0], bit_in};
    end

    assign word = sr_q;
endmodule

// File: rtl/serdiv_hold.sv
module serdiv_hold
    import serdiv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  word_t     word,
    output ref_cfg_t  ref_cfg,
    output prog_cfg_t prog_cfg
);
    ref_cfg_t  ref_q;
    prog_cfg_t prog_q;
    logic      to_ref;

    assign to_ref = word[0];

    always_ff @(posedge clk) begin
        if (rst)                  ref_q <= REF_RST;
        else if (load && to_ref)  ref_q <= word_to_ref(word);
    end

    always_ff @(posedge clk) begin
        if (rst)                  prog_q <= PROG_RST;
        else if (load && !to_ref) prog_q <= word_to_prog(word);
    end

    assign ref_cfg  = ref_q;
    assign prog_cfg = prog_q;
endmodule

// File: rtl/serdiv_prog_port.sv
module serdiv_prog_port
    import serdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ser_data,
    input  logic               ser_clk,
    input  logic               ser_le,
    output logic [RATIO_W-1:0] ref_ratio,
    output logic               ref_sw,
    output logic               ref_fc,
    output logic               ref_lds,
    output logic               ref_cs,
    output logic [N_W-1:0]     prog_n,
    output logic [A_W-1:0]     prog_a
);
    logic [2:0] lines_s;
    logic [1:0] rise;
    logic       data_s;
    logic       sclk_rise;
    logic       le_rise;
    word_t      word;
    ref_cfg_t   ref_cfg;
    prog_cfg_t  prog_cfg;

    serdiv_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ser_le, ser_clk, ser_data}),
        .dout (lines_s)
    );

    assign data_s = lines_s[0];

    serdiv_edge #(.WIDTH(2)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (lines_s[2:1]),
        .rise  (rise)
    );

    assign sclk_rise = rise[0];
    assign le_rise   = rise[1];

    serdiv_shreg u_shreg (
        .clk      (clk),
        .rst      (rst),
        .shift_en (sclk_rise),
        .bit_in   (data_s),
        .word     (word)
    );

    serdiv_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .load     (le_rise),
        .word     (word),
        .ref_cfg  (ref_cfg),
        .prog_cfg (prog_cfg)
    );

    assign ref_ratio = ref_cfg.ratio;
    assign ref_sw    = ref_cfg.sw;
    assign ref_fc    = ref_cfg.fc;
    assign ref_lds   = ref_cfg.lds;
    assign ref_cs    = ref_cfg.cs;
    assign prog_n    = prog_cfg.n;
    assign prog_a    = prog_cfg.a;
endmodule

// File: rtl/serdiv_prog_port_chk.sv
module serdiv_prog_port_chk
    import serdiv_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               sclk_rise,
    input logic               le_rise,
    input logic               data_s,
    input word_t              word,
    input logic [RATIO_W-1:0] ref_ratio,
    input logic               ref_sw,
    input logic               ref_fc,
    input logic               ref_lds,
    input logic               ref_cs,
    input logic [N_W-1:0]     prog_n,
    input logic [A_W-1:0]     prog_a
);
    // R1
    reset_defaults_chk: assert property (@(posedge clk)
        rst |=> (ref_ratio == RATIO_W'(RATIO_MIN) && prog_n == N_W'(N_MIN) &&
                 prog_a == '0 && !ref_sw && !ref_fc && !ref_lds && !ref_cs));

    // R2
    shift_in_chk: assert property (@(posedge clk) disable iff (rst)
        sclk_rise |=> (word[0] == $past(data_s) &&
                       word[WORD_W-1:1] == $past(word[WORD_W-2:0])));

    // R3
    ref_load_chk: assert property (@(posedge clk) disable iff (rst)
        (le_rise && word[0]) |=>
            (ref_ratio == $past(word[RATIO_LSB +: RATIO_W]) &&
             ref_sw == $past(word[SW_POS]) && ref_fc == $past(word[FC_POS]) &&
             ref_lds == $past(word[LDS_POS]) && ref_cs == $past(word[CS_POS])));

    // R4
    prog_load_chk: assert property (@(posedge clk) disable iff (rst)
        (le_rise && !word[0]) |=>
            (prog_a == $past(word[A_LSB +: A_W]) &&
             prog_n == $past(word[N_LSB +: N_W])));

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !le_rise |=> ($stable(ref_ratio) && $stable(ref_sw) && $stable(ref_fc) &&
                      $stable(ref_lds) && $stable(ref_cs) &&
                      $stable(prog_n) && $stable(prog_a)));

    // R6
    ref_isolation_chk: assert property (@(posedge clk) disable iff (rst)
        (le_rise && word[0]) |=> ($stable(prog_n) && $stable(prog_a)));

    // R6
    prog_isolation_chk: assert property (@(posedge clk) disable iff (rst)
        (le_rise && !word[0]) |=> ($stable(ref_ratio) && $stable(ref_sw) &&
                                   $stable(ref_fc) && $stable(ref_lds) &&
                                   $stable(ref_cs)));
endmodule

bind serdiv_prog_port serdiv_prog_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sclk_rise (sclk_rise),
    .le_rise   (le_rise),
    .data_s    (data_s),
    .word      (word),
    .ref_ratio (ref_ratio),
    .ref_sw    (ref_sw),
    .ref_fc    (ref_fc),
    .ref_lds   (ref_lds),
    .ref_cs    (ref_cs),
    .prog_n    (prog_n),
    .prog_a    (prog_a)
);

// File: tb/serdiv_prog_port_tb.sv
module serdiv_prog_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_data = 1'b0;
    logic        ser_clk  = 1'b0;
    logic        ser_le   = 1'b0;
    logic [13:0] ref_ratio;
    logic        ref_sw, ref_fc, ref_lds, ref_cs;
    logic [10:0] prog_n;
    logic [6:0]  prog_a;

    int checks = 0;
    int fails  = 0;
    bit settling = 1'b1;

    // Behavioural model: expected packed outputs
    logic [17:0] exp_ref  = {4'b0, 14'd3};
    logic [17:0] exp_prog = {11'd3, 7'd0};

    always #(CLK_PERIOD/2) clk = ~clk;

    serdiv_prog_port u_dut (
        .clk(clk), .rst(rst), .ser_data(ser_data), .ser_clk(ser_clk), .ser_le(ser_le),
        .ref_ratio(ref_ratio), .ref_sw(ref_sw), .ref_fc(ref_fc), .ref_lds(ref_lds),
        .ref_cs(ref_cs), .prog_n(prog_n), .prog_a(prog_a)
    );

    function automatic logic [35:0] actual();
        return {ref_cs, ref_lds, ref_fc, ref_sw, ref_ratio, prog_n, prog_a};
    endfunction

    // R3: bit0 = 1, ratio at 14:1, SW 15, FC 16, LDS 17, CS 18
    function automatic logic [18:0] mk_ref(input int ratio, input bit sw, input bit fc,
                                           input bit lds, input bit cs);
        return {cs, lds, fc, sw, 14'(ratio), 1'b1};
    endfunction

    // R4: bit0 = 0, A at 7:1, N at 18:8
    function automatic logic [18:0] mk_prog(input int n, input int a);
        return {11'(n), 7'(a), 1'b0};
    endfunction

    task automatic check(input bit ok, input string req, input logic [35:0] act,
                         input logic [35:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Continuous cycle-by-cycle comparison against the model (R5, R6)
    always @(negedge clk) begin
        if (!rst && !settling)
            check(actual() === {exp_ref, exp_prog}, "R5/R6 monitor",
                  actual(), {exp_ref, exp_prog});
    end

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // R2: MSB first, one bit per serial clock rising edge
    task automatic shift_bits(input logic [31:0] bits, input int count);
        for (int i = count - 1; i >= 0; i--) begin
            ser_data = bits[i];
            wait_clks(HALF_BIT);
            ser_clk = 1'b1;
            wait_clks(HALF_BIT);
            ser_clk = 1'b0;
        end
        wait_clks(HALF_BIT);
    endtask

    // R7: update on the third clock edge after latch enable rises
    task automatic latch(input logic [18:0] w, input string req);
        logic [17:0] new_ref, new_prog;
        new_ref  = w[0] ? w[18:1] : exp_ref;
        new_prog = w[0] ? exp_prog : w[18:1];
        settling = 1'b1;
        ser_le = 1'b1;
        wait_clks(2);
        check(actual() === {exp_ref, exp_prog}, "R7 before update",
              actual(), {exp_ref, exp_prog});
        wait_clks(1);
        check(actual() === {new_ref, new_prog}, req, actual(), {new_ref, new_prog});
        exp_ref  = new_ref;
        exp_prog = new_prog;
        settling = 1'b0;
        wait_clks(2);
        ser_le = 1'b0;
        wait_clks(HALF_BIT);
    endtask

    task automatic do_reset();
        settling = 1'b1;
        rst = 1'b1;
        wait_clks(4);
        rst = 1'b0;
        exp_ref  = {4'b0, 14'd3};
        exp_prog = {11'd3, 7'd0};
        wait_clks(1);
        check(actual() === {exp_ref, exp_prog}, "R1 reset defaults",
              actual(), {exp_ref, exp_prog});
        settling = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [18:0] w;
        do_reset();

        // R3 reference load, R6 main divider untouched
        w = mk_ref(1000, 1'b1, 1'b0, 1'b1, 1'b0);
        shift_bits(32'(w), 19);
        latch(w, "R3 reference load");

        // R4 main divider load, R6 reference untouched
        w = mk_prog(1234, 77);
        shift_bits(32'(w), 19);
        latch(w, "R4 main divider load");

        // R5 shift with latch enable low: no change
        w = mk_ref(5555, 1'b0, 1'b1, 1'b0, 1'b1);
        shift_bits(32'(w), 19);
        check(actual() === {exp_ref, exp_prog}, "R5 shift without latch",
              actual(), {exp_ref, exp_prog});
        latch(w, "R3 latch of held word");

        // R2 extra leading bits: only the last 19 count
        w = mk_prog(517, 3);
        shift_bits({7'h00, 6'b101101, w}, 25);
        latch(w, "R2 last 19 bits kept");

        // R5 latch enable held high while shifting: no relatch
        settling = 1'b1;
        ser_le = 1'b1;
        wait_clks(4);
        settling = 1'b0;
        w = mk_prog(9, 100);
        shift_bits(32'(w), 19);
        check(actual() === {exp_ref, exp_prog}, "R5 level-high no relatch",
              actual(), {exp_ref, exp_prog});
        ser_le = 1'b0;
        wait_clks(HALF_BIT);
        latch(w, "R4 latch after level-high");

        // Boundaries: all ones
        w = mk_ref(16383, 1'b1, 1'b1, 1'b1, 1'b1);
        shift_bits(32'(w), 19);
        latch(w, "R3 max ratio all flags");
        w = mk_prog(2047, 127);
        shift_bits(32'(w), 19);
        latch(w, "R4 max N and A");

        // Minimum legal values
        w = mk_ref(3, 1'b0, 1'b0, 1'b0, 1'b0);
        shift_bits(32'(w), 19);
        latch(w, "R3 min ratio");
        w = mk_prog(3, 0);
        shift_bits(32'(w), 19);
        latch(w, "R4 min N, A zero");

        // Reset mid-run after non-default contents
        w = mk_ref(8191, 1'b1, 1'b0, 1'b0, 1'b1);
        shift_bits(32'(w), 19);
        latch(w, "R3 before reset");
        do_reset();

        wait_clks(4);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule